// File: doc/BRIEF.md
# Two-Bank SRAM Arbiter for CPU and DMA Ports

This block sits in front of a dual-ported on-chip SRAM that is split into two 32 KB banks. One port belongs to the CPU and the other to a DMA (second-port) master. Each cycle, each bank can serve one access. When the two ports target different banks, both are served at once. When they target the same bank, a per-bank priority bit picks the winner. The losing port sees its ready low and keeps its request stable until it is served.

Accesses from the second port are allowed only while two enable bits are both set: one held for the CPU side and one held for the DMA side. While either enable is clear, a DMA request is refused. A refused request gets a one-cycle error response instead of a stall, and it leaves the memory untouched.

The memory behind each bank is a simple synchronous word array. Read data comes back one cycle after the access is accepted.

Top module: `sram_bank_arb`

## Requirements
- R1: After reset, both priority bits are 0, which gives the DMA port the win in both banks. Both second-port enables are 0. No ready, rvalid or error output is high while no request is present.
- R2: Bit 15 of the 16-bit byte address selects the bank (1 = upper, 0 = lower). Words are 32 bits wide, and address bits [1:0] are ignored. Equal offsets in the two banks hold independent data.
- R3: When both ports request the same bank in a cycle, exactly one of cpu_ready and dma_ready is high. The stalled port is served in a later cycle if it holds its request. A port that is not requesting never sees ready.
- R4: When both ports request different banks in the same cycle, both ready outputs are high in that cycle.
- R5: On a same-bank collision, the upper bank goes to the CPU when cfg_pri_up is 1 and to the DMA port when it is 0. The lower bank is settled the same way by cfg_pri_lo. The two bits act independently of each other.
- R6: A DMA request made while cfg_cpu_side_en and cfg_dma_side_en are not both 1 raises dma_err in that same cycle, holds dma_ready low, and causes no memory write.
- R7: An accepted write updates the addressed word at the end of its ready cycle. An accepted read returns the word on that port's rdata, with rvalid high, exactly one cycle after the ready cycle.
- R8: CPU accesses are served regardless of the second-port enables.
- R9: Configuration values presented with cfg_wr high take effect from the following cycle. A collision in the cfg_wr cycle itself is decided by the old priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load the four configuration values below |
| cfg_pri_up | input | 1 | Upper-bank priority: 1 = CPU wins |
| cfg_pri_lo | input | 1 | Lower-bank priority: 1 = CPU wins |
| cfg_cpu_side_en | input | 1 | CPU-side second-port enable |
| cfg_dma_side_en | input | 1 | DMA-side second-port enable |
| cpu_req | input | 1 | CPU request |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_ready | output | 1 | CPU access accepted this cycle |
| cpu_rvalid | output | 1 | CPU read data valid |
| cpu_rdata | output | 32 | CPU read data |
| dma_req | input | 1 | DMA request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | 16 | DMA byte address |
| dma_wdata | input | 32 | DMA write data |
| dma_ready | output | 1 | DMA access accepted this cycle |
| dma_err | output | 1 | DMA request refused this cycle |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | 32 | DMA read data |

## Verification
The hardest case to reach from the ports is a collision that lands in the very cycle a new priority is loaded. The stimulus creates it by raising cfg_wr together with two same-bank requests; the winner must follow the old setting, and the retried loser must follow the new one. The stimulus also pairs a refused DMA write with a CPU write to the same word, then reads the word back. This shows that the refused write left no trace. Collisions are run in each bank under all priority settings, so the two bits are checked for independence.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;
   localparam int NUM_BANKS = 2;
   typedef enum logic {OWN_DMA = 1'b0, OWN_CPU = 1'b1} owner_e;
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
   import sram_arb_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic                 pri_up,
   input  logic                 pri_lo,
   input  logic                 cpu_side_en,
   input  logic                 dma_side_en,
   output logic [NUM_BANKS-1:0] pri_q,
   output logic                 dma_allowed
);
   logic cpu_en_q, dma_en_q, armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pri_q    <= '0;
         cpu_en_q <= 1'b0;
         dma_en_q <= 1'b0;
         armed    <= 1'b0;
      end else begin
         armed <= 1'b1;
         if (wr) begin
            pri_q    <= {pri_up, pri_lo};
            cpu_en_q <= cpu_side_en;
            dma_en_q <= dma_side_en;
         end
      end
   end

   assign dma_allowed = cpu_en_q & dma_en_q;

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !$past(wr) |-> $stable(pri_q) && $stable(dma_allowed)); // R9
endmodule

// File: rtl/arb_bank_grant.sv
module arb_bank_grant
   import sram_arb_pkg::*;
#(
   parameter int BANK_ID = 0
) (
   input  logic   cpu_req,
   input  logic   cpu_bank,
   input  logic   dma_req,
   input  logic   dma_bank,
   input  logic   cpu_wins,
   output logic   gnt_cpu,
   output logic   gnt_dma,
   output owner_e owner
);
   logic hit_c, hit_d;

   always_comb begin
      hit_c   = cpu_req && (cpu_bank == 1'(BANK_ID));
      hit_d   = dma_req && (dma_bank == 1'(BANK_ID));
      gnt_cpu = hit_c && (!hit_d || cpu_wins);
      gnt_dma = hit_d && (!hit_c || !cpu_wins);
      owner   = gnt_cpu ? OWN_CPU : OWN_DMA;
   end
endmodule

// File: rtl/arb_bank_mem.sv
module arb_bank_mem #(
   parameter int DATA_W = 32,
   parameter int AW     = 8
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [AW-1:0]     idx,
   input  logic [DATA_W-1:0] wd,
   output logic [DATA_W-1:0] q
);
   localparam int DEPTH = 1 << AW;
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[idx] <= wd;
         else    q <= mem[idx];
      end
   end
endmodule

// File: rtl/sram_bank_arb.sv
module sram_bank_arb
   import sram_arb_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   parameter int MODEL_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_pri_up,
   input  logic              cfg_pri_lo,
   input  logic              cfg_cpu_side_en,
   input  logic              cfg_dma_side_en,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_rvalid,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              dma_req,
   input  logic              dma_we,
   input  logic [ADDR_W-1:0] dma_addr,
   input  logic [DATA_W-1:0] dma_wdata,
   output logic              dma_ready,
   output logic              dma_err,
   output logic              dma_rvalid,
   output logic [DATA_W-1:0] dma_rdata
);
   localparam int BANK_BIT = ADDR_W - 1;
   localparam int IDX_LO   = $clog2(DATA_W / 8);
   localparam int IDX_HI   = IDX_LO + MODEL_AW - 1;

   if ((DATA_W % 8) != 0 || (1 << IDX_LO) != DATA_W / 8) begin : g_bad_dw
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (IDX_HI + 1 >= BANK_BIT) begin : g_bad_aw
      $error("MODEL_AW too large for ADDR_W");
   end

   logic [NUM_BANKS-1:0] pri_q;
   logic                 dma_allowed, dma_live;
   logic                 cpu_bank, dma_bank;
   logic [MODEL_AW-1:0]  cpu_idx, dma_idx;
   logic [NUM_BANKS-1:0] gnt_cpu, gnt_dma;
   logic [DATA_W-1:0]    bank_q [NUM_BANKS];
   logic                 cpu_rbank_q, dma_rbank_q;
   logic                 unused_addr_bits;

   arb_cfg_regs u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
      .pri_up(cfg_pri_up), .pri_lo(cfg_pri_lo),
      .cpu_side_en(cfg_cpu_side_en), .dma_side_en(cfg_dma_side_en),
      .pri_q(pri_q), .dma_allowed(dma_allowed)
   );

   assign cpu_bank = cpu_addr[BANK_BIT];
   assign dma_bank = dma_addr[BANK_BIT];
   assign cpu_idx  = cpu_addr[IDX_HI:IDX_LO];
   assign dma_idx  = dma_addr[IDX_HI:IDX_LO];
   assign dma_live = dma_req & dma_allowed;
   assign unused_addr_bits = ^{cpu_addr[BANK_BIT-1:IDX_HI+1], cpu_addr[IDX_LO-1:0],
                               dma_addr[BANK_BIT-1:IDX_HI+1], dma_addr[IDX_LO-1:0]};

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      owner_e own;
      logic   en;

      arb_bank_grant #(.BANK_ID(b)) u_gnt (
         .cpu_req(cpu_req), .cpu_bank(cpu_bank),
         .dma_req(dma_live), .dma_bank(dma_bank),
         .cpu_wins(pri_q[b]),
         .gnt_cpu(gnt_cpu[b]), .gnt_dma(gnt_dma[b]), .owner(own)
      );

      assign en = gnt_cpu[b] | gnt_dma[b];

      arb_bank_mem #(.DATA_W(DATA_W), .AW(MODEL_AW)) u_mem (
         .clk(clk), .en(en),
         .we (own == OWN_CPU ? cpu_we    : dma_we),
         .idx(own == OWN_CPU ? cpu_idx   : dma_idx),
         .wd (own == OWN_CPU ? cpu_wdata : dma_wdata),
         .q  (bank_q[b])
      );
   end

   assign cpu_ready = |gnt_cpu;
   assign dma_ready = |gnt_dma;
   assign dma_err   = dma_req & ~dma_allowed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_rvalid  <= 1'b0;
         dma_rvalid  <= 1'b0;
         cpu_rbank_q <= 1'b0;
         dma_rbank_q <= 1'b0;
      end else begin
         cpu_rvalid <= cpu_ready & ~cpu_we;
         dma_rvalid <= dma_ready & ~dma_we;
         if (cpu_ready) cpu_rbank_q <= cpu_bank;
         if (dma_ready) dma_rbank_q <= dma_bank;
      end
   end

   assign cpu_rdata = bank_q[cpu_rbank_q];
   assign dma_rdata = bank_q[dma_rbank_q];

   AST_COLLIDE_ONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && dma_req && dma_allowed && (cpu_bank == dma_bank)
      |-> $countones({cpu_ready, dma_ready}) == 1); // R3
   AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |-> !cpu_ready); // R3
   AST_SPLIT_BOTH_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && dma_req && dma_allowed && (cpu_bank != dma_bank)
      |-> cpu_ready && dma_ready); // R4
   AST_CPU_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && dma_req && dma_allowed && (cpu_bank == dma_bank) && pri_q[cpu_bank]
      |-> cpu_ready); // R5
   AST_REFUSED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && !dma_allowed |-> dma_err && !dma_ready); // R6
   AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready && !cpu_we |=> cpu_rvalid); // R7
   AST_DMA_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      dma_ready && !dma_we |=> dma_rvalid); // R7
endmodule

// File: tb/sim_sram_bank_arb.sv
module sim_sram_bank_arb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 0, cfg_pri_up = 0, cfg_pri_lo = 0, cfg_cpu_side_en = 0, cfg_dma_side_en = 0;
   logic        cpu_req = 0, cpu_we = 0, dma_req = 0, dma_we = 0;
   logic [15:0] cpu_addr = '0, dma_addr = '0;
   logic [31:0] cpu_wdata = '0, dma_wdata = '0;
   logic        cpu_ready, cpu_rvalid, dma_ready, dma_err, dma_rvalid;
   logic [31:0] cpu_rdata, dma_rdata;

   int errors = 0;
   int checks = 0;
   logic [31:0] refm [logic [8:0]];
   logic [31:0] cpu_exp [$];
   logic [31:0] dma_exp [$];

   always #4 clk = ~clk;

   sram_bank_arb u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pri_up(cfg_pri_up),
      .cfg_pri_lo(cfg_pri_lo), .cfg_cpu_side_en(cfg_cpu_side_en),
      .cfg_dma_side_en(cfg_dma_side_en),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
      .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
      .dma_ready(dma_ready), .dma_err(dma_err), .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata)
   );

   function automatic logic [8:0] key(input logic [15:0] a);
      return {a[15], a[9:2]};
   endfunction

   // driver: inputs change just after a falling edge, ports are checked before the rising edge
   task automatic step(input logic cr, input logic cw, input logic [15:0] ca, input logic [31:0] cd,
                       input logic dr, input logic dw, input logic [15:0] da, input logic [31:0] dd,
                       input logic e_cr, input logic e_dr, input logic e_de, input string tag);
      cpu_req = cr; cpu_we = cw; cpu_addr = ca; cpu_wdata = cd;
      dma_req = dr; dma_we = dw; dma_addr = da; dma_wdata = dd;
      #3;
      checks++;
      if ({cpu_ready, dma_ready, dma_err} !== {e_cr, e_dr, e_de}) begin
         errors++;
         $display("FAIL %s: {cpu_ready,dma_ready,dma_err} actual=%b expected=%b",
                  tag, {cpu_ready, dma_ready, dma_err}, {e_cr, e_dr, e_de});
      end
      if (e_cr) begin
         if (cw) refm[key(ca)] = cd;
         else    cpu_exp.push_back(refm[key(ca)]);
      end
      if (e_dr) begin
         if (dw) refm[key(da)] = dd;
         else    dma_exp.push_back(refm[key(da)]);
      end
      @(negedge clk);
      cpu_req = 0; dma_req = 0;
   endtask

   task automatic set_cfg(input logic up, input logic lo, input logic ce, input logic de);
      cfg_pri_up = up; cfg_pri_lo = lo; cfg_cpu_side_en = ce; cfg_dma_side_en = de; cfg_wr = 1;
      @(negedge clk);
      cfg_wr = 0;
   endtask

   // monitor: read returns are compared against the scoreboard queues (R7)
   always @(negedge clk) begin
      if (rst_n) begin
         if (cpu_rvalid) begin
            checks++;
            if (cpu_exp.size() == 0) begin
               errors++; $display("FAIL R7: cpu_rvalid actual=1 expected=0");
            end else begin
               logic [31:0] e;
               e = cpu_exp.pop_front();
               if (cpu_rdata !== e) begin
                  errors++; $display("FAIL R7/R2: cpu_rdata actual=%h expected=%h", cpu_rdata, e);
               end
            end
         end
         if (dma_rvalid) begin
            checks++;
            if (dma_exp.size() == 0) begin
               errors++; $display("FAIL R7: dma_rvalid actual=1 expected=0");
            end else begin
               logic [31:0] e;
               e = dma_exp.pop_front();
               if (dma_rdata !== e) begin
                  errors++; $display("FAIL R7/R2: dma_rdata actual=%h expected=%h", dma_rdata, e);
               end
            end
         end
      end
   end

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #3;
      checks++;
      if ({cpu_ready, dma_ready, dma_err, cpu_rvalid, dma_rvalid} !== 5'b0) begin
         errors++; $display("FAIL R1: outputs actual=%b expected=00000",
                            {cpu_ready, dma_ready, dma_err, cpu_rvalid, dma_rvalid});
      end
      @(negedge clk);
      // R1 R6: second port refused after reset
      step(0,0,16'h0000,0, 1,0,16'h0040,0, 0,0,1, "R1 R6 refused after reset");
      // R8 R6: CPU write served while refused DMA write targets the same word
      step(1,1,16'h0040,32'hA1A1_0001, 1,1,16'h0040,32'hDEAD_BEEF, 1,0,1, "R8 R6 cpu write beside refused dma");
      step(1,0,16'h0040,0, 0,0,0,0, 1,0,0, "R6 R7 cpu reads back word");
      // only CPU-side enable set: still refused
      set_cfg(0,0,1,0);
      step(0,0,0,0, 1,0,16'h0040,0, 0,0,1, "R6 one enable only");
      set_cfg(0,0,0,1);
      step(0,0,0,0, 1,0,16'h0040,0, 0,0,1, "R6 other enable only");
      set_cfg(0,0,1,1);
      // R3 R5: lower-bank collision with reset priority, DMA wins, CPU retries
      step(1,1,16'h0080,32'hC1C1_0002, 1,1,16'h0084,32'hD1D1_0003, 0,1,0, "R3 R5 lower clash dma wins");
      step(1,1,16'h0080,32'hC1C1_0002, 0,0,0,0, 1,0,0, "R3 cpu retry served");
      // R4 R2: different banks served together
      step(1,1,16'h8080,32'hE1E1_0004, 1,0,16'h0080,0, 1,1,0, "R4 split banks both served");
      step(1,0,16'h0080,0, 1,0,16'h8080,0, 1,1,0, "R2 R4 same offset different banks");
      // R9: priority loaded in a collision cycle, old value decides
      cfg_pri_up = 1; cfg_pri_lo = 0; cfg_wr = 1;
      step(1,0,16'h8080,0, 1,1,16'h8084,32'hD2D2_0005, 0,1,0, "R9 old priority in cfg cycle");
      cfg_wr = 0;
      step(1,0,16'h8080,0, 0,0,0,0, 1,0,0, "R3 cpu retry after cfg");
      // R5: upper CPU wins, lower DMA wins
      step(1,0,16'h8084,0, 1,0,16'h8080,0, 1,0,0, "R5 upper clash cpu wins");
      step(0,0,0,0, 1,0,16'h8080,0, 0,1,0, "R3 dma retry served");
      step(1,0,16'h0040,0, 1,0,16'h0084,0, 0,1,0, "R5 lower clash dma wins");
      step(1,0,16'h0040,0, 0,0,0,0, 1,0,0, "R3 cpu retry lower");
      // R5: swap the two bits
      set_cfg(0,1,1,1);
      step(1,1,16'h0088,32'hF0F0_0006, 1,0,16'h0080,0, 1,0,0, "R5 lower clash cpu wins");
      step(1,1,16'h8088,32'hF1F1_0007, 1,0,16'h8084,0, 0,1,0, "R5 upper clash dma wins");
      step(1,1,16'h8088,32'hF1F1_0007, 0,0,0,0, 1,0,0, "R3 cpu retry upper");
      step(1,0,16'h8088,0, 1,0,16'h0088,0, 1,1,0, "R4 R2 readback");
      // R6: dropping one enable refuses the DMA port again, CPU unaffected (R8)
      set_cfg(0,1,0,1);
      step(1,0,16'h0088,0, 1,1,16'h0088,32'h0BAD_0BAD, 1,0,1, "R6 R8 disabled again");
      step(1,0,16'h0088,0, 0,0,0,0, 1,0,0, "R6 word unchanged");
      repeat (3) @(negedge clk);
      checks++;
      if (cpu_exp.size() != 0 || dma_exp.size() != 0) begin
         errors++; $display("FAIL R7: pending reads actual=%0d expected=0", cpu_exp.size() + dma_exp.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule